// File: doc/BRIEF.md
# Bus-Attached Addressable Memory Module

This block is a word-wide storage module that sits on a shared processor bus, where one set of wires carries both addresses and data. A local address register captures the bus word when the load strobe is high. The upper bits of that register name a module. They are compared with a constant identity input strapped at the instance, so several modules with distinct identities tile the full address space. The lower bits select one word of the local storage array.

When the read strobe is high and the identity matches, the module presents the selected word in the same cycle. It does this through a data-out port plus an output enable, not a tri-state driver. The outputs of all modules can then be ORed together. When the store strobe is high and the identity matches, the word currently on the bus is written at the next rising edge.

With `BUS_W` = 16 and `ID_W` = 3, each module holds 8192 words and eight modules cover a 64K-word space. The parameter defaults are smaller so that the storage stays small when the block is elaborated on its own.

Top module: `bus_mem_module`

## Requirements
- R1: Asynchronous active-low reset clears the address register to zero. A module strapped with identity 0 therefore asserts `bus_oe` on a read right after reset, and modules with other identities do not.
- R2: On a rising edge with `ld_addr` high, the address register takes `bus_in`. Without `ld_addr` it holds its value, whatever `bus_in` carries.
- R3: `bus_oe` is high exactly when `rd_en` is high and address bits [BUS_W-1 : BUS_W-ID_W] equal `id_strap`.
- R4: While `bus_oe` is high, `bus_out` equals the stored word at index address[BUS_W-ID_W-1:0]. It is valid in the same cycle that `rd_en` rises, with no clock edge in between.
- R5: On a rising edge with `st_en` high and the identity matching, `bus_in` is written at the indexed word.
- R6: A store whose identity does not match leaves every word of the module unchanged.
- R7: While `bus_oe` is low, `bus_out` is all zeros.
- R8: For modules with distinct identities on one bus, at most one asserts `bus_oe` in any cycle.
- R9: When `ld_addr` and `st_en` are high in the same cycle, the store uses the address held before that edge. The register then takes the new bus value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_in | input | BUS_W | Shared bus word (address or data) |
| ld_addr | input | 1 | Load the address register from the bus |
| rd_en | input | 1 | Read strobe |
| st_en | input | 1 | Store strobe |
| id_strap | input | ID_W | Hard-wired module identity |
| bus_out | output | BUS_W | Word presented to the bus, zero when not enabled |
| bus_oe | output | 1 | Output enable toward the bus |

## Verification
The bench builds three modules with `BUS_W` = 8 and `ID_W` = 3, strapped to identities 2, 5 and 0. Each module then holds 32 words, small enough to write and read back every location of one module. The index width of 5 bits shows whether identity and index bits are split at the right position. Identity 0 makes the reset value of the address register visible at the ports. The two other identities, together with an address naming no module, cover matching, mismatching and exclusive driving on one bus.

// File: rtl/bm_pkg.sv
package bm_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'b00,
    ACC_READ  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_BOTH  = 2'b11
  } access_e;

  function automatic access_e classify(input logic hit, input logic rd, input logic st);
    return access_e'({hit & st, hit & rd});
  endfunction

endpackage

// File: rtl/bm_addr_reg.sv
module bm_addr_reg #(
  parameter int BUS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [BUS_W-1:0] d,
  output logic [BUS_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (ld) q <= d;
  end

  a_r2_load_takes_bus: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> q == $past(d));
  a_r2_hold_without_load: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(q));

endmodule

// File: rtl/bm_id_match.sv
module bm_id_match #(
  parameter int BUS_W = 12,
  parameter int ID_W  = 3
) (
  input  logic [BUS_W-1:0]      addr,
  input  logic [ID_W-1:0]       id,
  output logic                  hit,
  output logic [BUS_W-ID_W-1:0] index
);

  localparam int IDX_W = BUS_W - ID_W;

  function automatic logic [ID_W-1:0] upper_of(input logic [BUS_W-1:0] a);
    return a[BUS_W-1 -: ID_W];
  endfunction

  function automatic logic [IDX_W-1:0] lower_of(input logic [BUS_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  assign hit   = (upper_of(addr) == id);
  assign index = lower_of(addr);

endmodule

// File: rtl/bm_word_store.sv
module bm_word_store #(
  parameter int WORD_W = 12,
  parameter int IDX_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[idx] <= wdata;
  end

  assign rdata = cells[idx];

  a_r5_written_word_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !$isunknown(idx)) |=> cells[$past(idx)] == $past(wdata));

endmodule

// File: rtl/bus_mem_module.sv
module bus_mem_module
  import bm_pkg::*;
#(
  parameter int BUS_W = 12,
  parameter int ID_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_in,
  input  logic             ld_addr,
  input  logic             rd_en,
  input  logic             st_en,
  input  logic [ID_W-1:0]  id_strap,
  output logic [BUS_W-1:0] bus_out,
  output logic             bus_oe
);

  localparam int IDX_W = BUS_W - ID_W;

  logic [BUS_W-1:0] addr_q;
  logic             id_hit;
  logic [IDX_W-1:0] word_idx;
  logic [BUS_W-1:0] stored_word;
  access_e          access;
  logic             wr_fire;
  logic             rd_fire;

  bm_addr_reg #(.BUS_W(BUS_W)) u_areg (
    .clk(clk), .rst_n(rst_n), .ld(ld_addr), .d(bus_in), .q(addr_q)
  );

  bm_id_match #(.BUS_W(BUS_W), .ID_W(ID_W)) u_match (
    .addr(addr_q), .id(id_strap), .hit(id_hit), .index(word_idx)
  );

  assign access  = classify(id_hit, rd_en, st_en);
  assign wr_fire = (access == ACC_STORE) || (access == ACC_BOTH);
  assign rd_fire = (access == ACC_READ)  || (access == ACC_BOTH);

  bm_word_store #(.WORD_W(BUS_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .idx(word_idx),
    .wdata(bus_in), .rdata(stored_word)
  );

  assign bus_oe  = rd_fire;
  assign bus_out = rd_fire ? stored_word : '0;

  a_r7_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_out == '0);
  a_r3_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> rd_en);
  a_r6_no_write_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q[BUS_W-1 -: ID_W] != id_strap) |-> !wr_fire);
  a_r9_store_uses_old_address: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_addr && st_en) |=> addr_q == $past(bus_in));

endmodule

// File: tb/sim_bus_mem_module.sv
module sim_bus_mem_module;

  localparam int BW = 8;
  localparam int IW = 3;
  localparam int NWORDS = 1 << (BW - IW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [BW-1:0] bus_in = '0;
  logic ld = 1'b0, rd = 1'b0, st = 1'b0;
  logic [BW-1:0] out0, out1, out2;
  logic oe0, oe1, oe2;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_mem_module #(.BUS_W(BW), .ID_W(IW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .ld_addr(ld), .rd_en(rd),
    .st_en(st), .id_strap(3'd2), .bus_out(out0), .bus_oe(oe0));
  bus_mem_module #(.BUS_W(BW), .ID_W(IW)) u1 (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .ld_addr(ld), .rd_en(rd),
    .st_en(st), .id_strap(3'd5), .bus_out(out1), .bus_oe(oe1));
  bus_mem_module #(.BUS_W(BW), .ID_W(IW)) u2 (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .ld_addr(ld), .rd_en(rd),
    .st_en(st), .id_strap(3'd0), .bus_out(out2), .bus_oe(oe2));

  task automatic check(input bit ok, input string req, input logic [BW-1:0] act,
                       input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One microcycle: drive at the falling edge, sample the combinational
  // outputs before the rising edge, then let the edge happen.
  task automatic step(input bit l, input bit r, input bit s, input logic [BW-1:0] v,
                      input bit chk, input bit e0, input bit e1,
                      input logic [BW-1:0] eb, input string req);
    @(negedge clk);
    ld = l; rd = r; st = s; bus_in = v;
    #2;
    if (chk) begin
      check(oe0 == e0, {req, " oe of id 2"}, {7'd0, oe0}, {7'd0, e0});
      check(oe1 == e1, {req, " oe of id 5"}, {7'd0, oe1}, {7'd0, e1});
      check((out0 | out1) == eb, {req, " bus word"}, out0 | out1, eb);
      check(!oe2, "R3 id 0 stays off", {7'd0, oe2}, 8'd0);
    end
    if (!oe0) check(out0 == '0, "R7 quiet id 2", out0, 8'd0);
    if (!oe1) check(out1 == '0, "R7 quiet id 5", out1, 8'd0);
    check(!(oe0 && oe1), "R8 exclusive drive", {6'd0, oe0, oe1}, 8'd0);
    @(posedge clk);
  endtask

  // op[19:18]: 0 load, 1 store, 2 read; val[17:10]; oe id2 [9]; oe id5 [8]; bus [7:0]
  localparam int NV = 14;
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 8'h43, 1'b0, 1'b0, 8'h00},  // R2 load id 2, index 3
    {2'd1, 8'h5A, 1'b0, 1'b0, 8'h00},  // R5 store to id 2
    {2'd2, 8'hA5, 1'b1, 1'b0, 8'h5A},  // R4 R2 read back, bus value differs
    {2'd0, 8'hA3, 1'b0, 1'b0, 8'h00},  // load id 5, index 3
    {2'd1, 8'hC3, 1'b0, 1'b0, 8'h00},  // R5 store to id 5
    {2'd2, 8'h00, 1'b0, 1'b1, 8'hC3},  // R3 only id 5 drives
    {2'd0, 8'h23, 1'b0, 1'b0, 8'h00},  // address naming id 1 (no module)
    {2'd1, 8'hFF, 1'b0, 1'b0, 8'h00},  // R6 store that matches nobody
    {2'd2, 8'h00, 1'b0, 1'b0, 8'h00},  // R3 no module responds
    {2'd0, 8'h43, 1'b0, 1'b0, 8'h00},
    {2'd2, 8'h00, 1'b1, 1'b0, 8'h5A},  // R6 id 2 word unchanged
    {2'd0, 8'hA3, 1'b0, 1'b0, 8'h00},
    {2'd2, 8'h00, 1'b0, 1'b1, 8'hC3},  // R6 id 5 word unchanged
    {2'd2, 8'h77, 1'b0, 1'b1, 8'hC3}   // R2 held address across reads
  };

  function automatic logic [BW-1:0] pattern(input int i);
    return 8'((i * 37 + 11) ^ (i << 3));
  endfunction

  initial begin
    #10000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: address 0 after reset selects the id 0 module
    @(negedge clk);
    rd = 1'b1;
    #2;
    check(oe2 == 1'b1, "R1 id 0 selected after reset", {7'd0, oe2}, 8'd1);
    check(!oe0 && !oe1, "R1 other ids silent after reset", {6'd0, oe0, oe1}, 8'd0);
    check(out0 == '0 && out1 == '0, "R7 silent modules drive zero", out0 | out1, 8'd0);
    @(posedge clk);
    rd = 1'b0;

    for (int k = 0; k < NV; k++) begin
      logic [1:0] op;
      op = VEC[k][19:18];
      step(op == 2'd0, op == 2'd2, op == 2'd1, VEC[k][17:10], 1'b1,
           VEC[k][9], VEC[k][8], VEC[k][7:0], $sformatf("R3/R4 vector %0d", k));
    end

    // R9: load and store together, the store goes to the old address (id 2, index 3)
    step(1'b1, 1'b0, 1'b0, 8'h43, 1'b0, 1'b0, 1'b0, 8'h00, "R9 setup");
    step(1'b1, 1'b0, 1'b1, 8'h47, 1'b0, 1'b0, 1'b0, 8'h00, "R9 load+store");
    step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, "R9 probe");
    step(1'b1, 1'b0, 1'b0, 8'h43, 1'b0, 1'b0, 1'b0, 8'h00, "R9 reload");
    @(negedge clk);
    rd = 1'b1;
    #2;
    check(oe0 && out0 == 8'h47, "R9 old address written", out0, 8'h47);
    @(posedge clk);
    rd = 1'b0;

    // R4 R5: sweep every word of the id 2 module
    for (int i = 0; i < NWORDS; i++) begin
      step(1'b1, 1'b0, 1'b0, 8'(8'h40 | i), 1'b0, 1'b0, 1'b0, 8'h00, "R5 sweep load");
      step(1'b0, 1'b0, 1'b1, pattern(i), 1'b0, 1'b0, 1'b0, 8'h00, "R5 sweep store");
    end
    for (int i = 0; i < NWORDS; i++) begin
      step(1'b1, 1'b0, 1'b0, 8'(8'h40 | i), 1'b0, 1'b0, 1'b0, 8'h00, "R4 sweep load");
      step(1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, pattern(i), "R4 sweep read");
    end

    // R6: an id 5 store at index 3 must not touch the id 2 word there
    step(1'b1, 1'b0, 1'b0, 8'hA3, 1'b0, 1'b0, 1'b0, 8'h00, "R6 load id 5");
    step(1'b0, 1'b0, 1'b1, 8'h99, 1'b0, 1'b0, 1'b0, 8'h00, "R6 store id 5");
    step(1'b1, 1'b0, 1'b0, 8'h43, 1'b0, 1'b0, 1'b0, 8'h00, "R6 load id 2");
    step(1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, pattern(3), "R6 id 2 untouched");

    @(negedge clk);
    ld = 1'b0; rd = 1'b0; st = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule